// File: doc/BRIEF.md
# Dual-Mode Host Register Bus Interface

This block is the slave side of an 8-bit host processor bus. It sits in front of two banks of internal register space. Two static straps fix how it reads the bus. The first strap picks the bus style: one style has a separate address bus and a data-only byte lane, and the other carries the low address byte and then the data on one shared lane. The second strap picks the timing: in strobe-timed mode the bus controls are used as they arrive, and in clock-sampled mode they first pass through a two-stage synchronizer.

The address is captured on the falling edge of the address strobe. Two active-low chip selects choose the lower or the upper bank. The block issues a single-cycle internal write pulse that carries the bank and the data. It enables the byte-lane output driver only while a read is valid. The bidirectional lane is split into `ad_in`, `ad_out` and `ad_oe`. A small register array in each bank stands in for the real register contents, so that written data can be read back.

Top module: `hbus_if`

## Requirements
- R1: While `rst` is high and after its release, `ad_oe` is 0, `wr_stb` is 0, `reg_addr` is 0 and every stand-in register reads 0.
- R2: On a clock edge where `as_n` is seen low after being seen high, `reg_addr` loads the address. With `intel_mode`=0 this is all of `addr_in`. At all other times `reg_addr` holds its value.
- R3: With `intel_mode`=1 the captured address is {`addr_in[11:8]`, `ad_in[7:0]`}, and `addr_in[7:0]` has no effect.
- R4: While neither chip select is low, no write commits and `ad_oe` stays 0.
- R5: When both chip selects are low at once, no access takes place. `ad_oe` stays 0 and a write strobe commits nothing.
- R6: A read is active as follows. With `intel_mode`=0 it is active while `ds_n`=0 and `rw_n`=1. With `intel_mode`=1 it is active while `ds_n`=0. When a read is active and exactly one chip select is low, `ad_oe` is 1 in the same cycle and `ad_out` shows the register at `reg_addr` in the selected bank.
- R7: A write strobe is active as follows. With `intel_mode`=0 it is active while `ds_n`=0 and `rw_n`=0. With `intel_mode`=1 it is active while `rw_n`=0. In strobe-timed mode (`sync_mode`=0), releasing the write strobe while one chip select is still low raises `wr_stb` for exactly one cycle, on the next clock edge. The pulse carries the data that was present while the strobe was active.
- R8: In strobe-timed mode, a write whose chip select is released before its write strobe commits nothing, and the register keeps its old value.
- R9: In clock-sampled mode (`sync_mode`=1), `wr_stb` rises on the third rising clock edge after the write strobe is asserted. The data is taken from `ad_in`. A strobe held for many cycles commits once, and the next commit needs the strobe to be seen inactive first.
- R10: `cs_n` = 2'b10 selects bank 0 and `cs_n` = 2'b01 selects bank 1. `wr_bank` reports the selected bank. The two banks hold independent values at the same address, indexed by `reg_addr[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the processor clock in clock-sampled mode |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode | input | 1 | 1: controls are sampled through a synchronizer; 0: strobe-timed |
| intel_mode | input | 1 | 1: multiplexed address/data lane; 0: separate address bus |
| as_n | input | 1 | Address strobe, active low; its falling edge captures the address |
| cs_n | input | 2 | Active-low bank selects, bit 0 for bank 0 and bit 1 for bank 1 |
| ds_n | input | 1 | Data strobe, or read strobe in multiplexed style |
| rw_n | input | 1 | Read/write direction, or write strobe in multiplexed style |
| addr_in | input | 12 | Address bus; only bits 11:8 are used in multiplexed style |
| ad_in | input | 8 | Byte lane, inbound |
| ad_out | output | 8 | Byte lane, outbound read data |
| ad_oe | output | 1 | Output enable for the byte lane |
| reg_addr | output | 12 | Captured register address |
| wr_stb | output | 1 | Single-cycle internal register write enable |
| wr_bank | output | 1 | Bank of the committed write |
| wr_data | output | 8 | Data of the committed write |

## Verification
Read data and `ad_oe` follow the pins combinationally, so the bench checks them 1 ns after driving the controls. `reg_addr` is checked at the falling edge that follows the capturing rising edge. In strobe-timed mode `wr_stb` is due one edge after the strobe is released. In clock-sampled mode it is due on the third edge after assertion. The bench drives inputs on falling edges and samples the pulse at each following falling edge, so it can tell a late or doubled pulse from a correct one. A pulse counter, sampled after each falling edge, shows that held strobes, aborted writes, contention and idle chip selects add no commits. Readback through the byte lane confirms what each bank holds.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    typedef struct packed {
        logic [1:0] cs_n;
        logic       ds_n;
        logic       rw_n;
    } strobe_t;

    typedef struct packed {
        logic ok;
        logic sel;
    } bank_t;

    function automatic logic rd_active(strobe_t s, logic intel);
        return intel ? !s.ds_n : (!s.ds_n && s.rw_n);
    endfunction

    function automatic logic wr_active(strobe_t s, logic intel);
        return intel ? !s.rw_n : (!s.ds_n && !s.rw_n);
    endfunction

    function automatic bank_t bank_of(logic [1:0] cs_n);
        bank_t b;
        case (cs_n)
            2'b10:   b = '{ok: 1'b1, sel: 1'b0};
            2'b01:   b = '{ok: 1'b1, sel: 1'b1};
            default: b = '{ok: 1'b0, sel: 1'b0};
        endcase
        return b;
    endfunction

endpackage

// File: rtl/hbus_strobe_front.sv
module hbus_strobe_front
    import hbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sync_mode,
    input  strobe_t raw,
    output strobe_t eff
);

    strobe_t chain [SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= '1;
        end else begin
            chain[0] <= raw;
            for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign eff = sync_mode ? chain[SYNC_STAGES-1] : raw;

endmodule

// File: rtl/hbus_addr_latch.sv
module hbus_addr_latch #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              intel_mode,
    input  logic              as_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] ad_in,
    output logic [ADDR_W-1:0] addr_q
);

    localparam int HI_W = ADDR_W - DATA_W;

    logic as_q;
    logic [ADDR_W-1:0] next_addr;

    assign next_addr = intel_mode ? {addr_in[ADDR_W-1 -: HI_W], ad_in} : addr_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            as_q   <= 1'b1;
            addr_q <= '0;
        end else begin
            as_q <= as_n;
            if (as_q && !as_n) addr_q <= next_addr;
        end
    end

    // R2: with the strobe high, the address is held over the next edge
    a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
        as_n |=> $stable(addr_q));

endmodule

// File: rtl/hbus_reg_bank.sv
module hbus_reg_bank #(
    parameter int DATA_W = 8,
    parameter int REG_AW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << REG_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/hbus_if.sv
module hbus_if
    import hbus_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 8,
    parameter int REG_AW      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_mode,
    input  logic              intel_mode,
    input  logic              as_n,
    input  logic [1:0]        cs_n,
    input  logic              ds_n,
    input  logic              rw_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              wr_stb,
    output logic              wr_bank,
    output logic [DATA_W-1:0] wr_data
);

    localparam int NBANK = 2;

    strobe_t raw_s, eff_s;
    bank_t   raw_bank, eff_bank;
    logic    wr_now, wr_prev, fire;
    logic [DATA_W-1:0] hold_data, fire_data;
    logic [DATA_W-1:0] rdata [NBANK];

    assign raw_s = {cs_n, ds_n, rw_n};

    hbus_strobe_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst(rst), .sync_mode(sync_mode), .raw(raw_s), .eff(eff_s)
    );

    hbus_addr_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
        .clk(clk), .rst(rst), .intel_mode(intel_mode), .as_n(as_n),
        .addr_in(addr_in), .ad_in(ad_in), .addr_q(reg_addr)
    );

    assign eff_bank = bank_of(eff_s.cs_n);
    assign raw_bank = bank_of(cs_n);
    assign wr_now   = wr_active(eff_s, intel_mode) && eff_bank.ok;

    // commit point: first sampled assertion, or release while still selected
    always_comb begin
        if (sync_mode) begin
            fire      = wr_now && !wr_prev;
            fire_data = ad_in;
        end else begin
            fire      = wr_prev && !wr_active(eff_s, intel_mode) && eff_bank.ok;
            fire_data = hold_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_prev   <= 1'b0;
            hold_data <= '0;
            wr_stb    <= 1'b0;
            wr_bank   <= 1'b0;
            wr_data   <= '0;
        end else begin
            wr_prev <= wr_now;
            if (wr_now) hold_data <= ad_in;
            wr_stb <= fire;
            if (fire) begin
                wr_bank <= eff_bank.sel;
                wr_data <= fire_data;
            end
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        hbus_reg_bank #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_bank (
            .clk(clk), .rst(rst),
            .we(wr_stb && (wr_bank == 1'(b))),
            .idx(reg_addr[REG_AW-1:0]),
            .wdata(wr_data),
            .rdata(rdata[b])
        );
    end

    assign ad_oe  = rd_active(raw_s, intel_mode) && raw_bank.ok;
    assign ad_out = ad_oe ? rdata[raw_bank.sel] : '0;

    // R7: a commit is never longer than one cycle
    a_r7_one_pulse: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R4: no commit follows a cycle with no effective chip select
    a_r4_idle_no_commit: assert property (@(posedge clk) disable iff (rst)
        $past(&eff_s.cs_n) |-> !wr_stb);

    // R5: both selects low never drives the lane
    a_r5_contention_quiet: assert property (@(posedge clk) disable iff (rst)
        (cs_n == 2'b00) |-> !ad_oe);

    // R1: reset leaves no pulse behind
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> !wr_stb);

endmodule

// File: tb/sim_hbus_if.sv
module sim_hbus_if;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst = 1'b1;
    logic sync_mode = 1'b0, intel_mode = 1'b0;
    logic as_n = 1'b1, ds_n = 1'b1, rw_n = 1'b1;
    logic [1:0] cs_n = 2'b11;
    logic [11:0] addr_in = '0;
    logic [7:0]  ad_in = '0;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [11:0] reg_addr;
    logic        wr_stb, wr_bank;
    logic [7:0]  wr_data;

    int n_chk = 0, n_fail = 0, pulses = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hbus_if u0 (
        .clk(clk), .rst(rst), .sync_mode(sync_mode), .intel_mode(intel_mode),
        .as_n(as_n), .cs_n(cs_n), .ds_n(ds_n), .rw_n(rw_n),
        .addr_in(addr_in), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .reg_addr(reg_addr), .wr_stb(wr_stb), .wr_bank(wr_bank), .wr_data(wr_data)
    );

    always @(negedge clk) begin
        #1;
        if (!rst && wr_stb) pulses++;
    end

    // {intel, bank, addr[11:0], data[7:0]}
    localparam logic [21:0] VEC [6] = '{
        {1'b0, 1'b0, 12'h003, 8'hA5},
        {1'b0, 1'b1, 12'h003, 8'h3C},
        {1'b1, 1'b0, 12'h7F9, 8'h11},
        {1'b1, 1'b1, 12'hA0E, 8'hE7},
        {1'b0, 1'b0, 12'hFFF, 8'h80},
        {1'b1, 1'b1, 12'h000, 8'hFF}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        as_n = 1'b1; ds_n = 1'b1; rw_n = 1'b1; cs_n = 2'b11;
    endtask

    task automatic set_write(input bit intel);
        if (intel) begin ds_n = 1'b1; rw_n = 1'b0; end
        else       begin ds_n = 1'b0; rw_n = 1'b0; end
    endtask

    task automatic latch(input bit intel, input logic [11:0] a);
        @(negedge clk);
        intel_mode = intel;
        addr_in = intel ? {a[11:8], ~a[7:0]} : a;
        ad_in   = intel ? a[7:0] : 8'h5A;
        as_n = 1'b0;
        @(negedge clk);
        as_n = 1'b1;
        #1 chk(reg_addr == a, intel ? "R3 muxed address" : "R2 address capture", reg_addr, a);
    endtask

    task automatic async_write(input bit intel, input bit bank, input logic [7:0] d);
        @(negedge clk);
        cs_n = bank ? 2'b01 : 2'b10;
        ad_in = d;
        set_write(intel);
        @(negedge clk);
        @(negedge clk);
        ds_n = 1'b1; rw_n = 1'b1;
        @(negedge clk);
        #1 chk(wr_stb && wr_bank == bank && wr_data == d, "R7 commit on release",
               {wr_stb, 3'b0, wr_bank, wr_data}, {4'h1, 3'b0, bank, d});
        cs_n = 2'b11;
        @(negedge clk);
        #1 chk(!wr_stb, "R7 single pulse", wr_stb, 0);
    endtask

    task automatic read_chk(input bit bank, input logic [7:0] exp, input string req);
        @(negedge clk);
        cs_n = bank ? 2'b01 : 2'b10;
        ds_n = 1'b0; rw_n = 1'b1;
        #1 chk(ad_oe && ad_out == exp, req, {ad_oe, ad_out}, {1'b1, exp});
        @(negedge clk);
        idle();
    endtask

    initial begin
        int p0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1 chk(!ad_oe && !wr_stb && reg_addr == 0, "R1 reset outputs", {ad_oe, wr_stb, reg_addr}, 0);
        read_chk(1'b1, 8'h00, "R1 reset register value");

        // vector table: capture, write, read back
        for (int i = 0; i < 6; i++) begin
            latch(VEC[i][21], VEC[i][19:8]);
            p0 = pulses;
            async_write(VEC[i][21], VEC[i][20], VEC[i][7:0]);
            chk(pulses == p0 + 1, "R7 exactly one commit", pulses, p0 + 1);
            read_chk(VEC[i][20], VEC[i][7:0], "R6 read back");
        end
        latch(1'b0, 12'h003);
        read_chk(1'b0, 8'hA5, "R10 bank 0 independent of bank 1");
        read_chk(1'b1, 8'h3C, "R10 bank 1 independent of bank 0");

        // R8: chip select released before the strobe
        latch(1'b0, 12'h006);
        async_write(1'b0, 1'b1, 8'h77);
        p0 = pulses;
        @(negedge clk); cs_n = 2'b01; ad_in = 8'h99; set_write(1'b0);
        @(negedge clk);
        @(negedge clk); cs_n = 2'b11;
        @(negedge clk); ds_n = 1'b1; rw_n = 1'b1;
        repeat (3) @(negedge clk);
        #2 chk(pulses == p0, "R8 aborted write no commit", pulses, p0);
        read_chk(1'b1, 8'h77, "R8 register unchanged");

        // R5: both selects low
        @(negedge clk); cs_n = 2'b00; ds_n = 1'b0; rw_n = 1'b1;
        #1 chk(!ad_oe, "R5 no drive on contention", ad_oe, 0);
        p0 = pulses;
        @(negedge clk); ad_in = 8'hEE; set_write(1'b0);
        @(negedge clk);
        @(negedge clk); ds_n = 1'b1; rw_n = 1'b1;
        repeat (3) @(negedge clk);
        #2 chk(pulses == p0, "R5 no commit on contention", pulses, p0);
        idle();
        read_chk(1'b0, 8'h00, "R5 bank 0 untouched");

        // R4: no chip select
        @(negedge clk); cs_n = 2'b11; ds_n = 1'b0; rw_n = 1'b1;
        #1 chk(!ad_oe, "R4 no drive without select", ad_oe, 0);
        p0 = pulses;
        @(negedge clk); ad_in = 8'h12; set_write(1'b0);
        @(negedge clk);
        @(negedge clk); ds_n = 1'b1; rw_n = 1'b1;
        repeat (3) @(negedge clk);
        #2 chk(pulses == p0, "R4 no commit without select", pulses, p0);

        // R9: clock-sampled mode
        @(negedge clk); idle(); sync_mode = 1'b1;
        repeat (3) @(negedge clk);
        latch(1'b0, 12'h005);
        p0 = pulses;
        @(negedge clk); cs_n = 2'b10; ad_in = 8'h42; set_write(1'b0);
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            #1 chk(wr_stb == (k == 3), "R9 sync commit latency", wr_stb, (k == 3));
        end
        repeat (6) @(negedge clk);
        #2 chk(pulses == p0 + 1, "R9 held strobe commits once", pulses, p0 + 1);
        ds_n = 1'b1; rw_n = 1'b1;
        repeat (4) @(negedge clk);
        ad_in = 8'h43; set_write(1'b0);
        repeat (6) @(negedge clk);
        ds_n = 1'b1; rw_n = 1'b1;
        repeat (4) @(negedge clk);
        #2 chk(pulses == p0 + 2, "R9 second commit after release", pulses, p0 + 2);
        idle();
        read_chk(1'b0, 8'h43, "R9 sync write data");
        @(negedge clk); sync_mode = 1'b0;
        repeat (3) @(negedge clk);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule